// File: doc/BRIEF.md
# Edge/Level Interrupt Source Register

This block gathers three interrupt sources into a single byte-wide register and turns them into one active-high interrupt request. Two of the sources are event sources: a rising edge on an external trigger input and a rising edge on a timer output. Each of them is caught by a small per-source state machine and held until software acknowledges it. The third source is a level request from a DAC FIFO. Its status bit simply follows the synchronised input.

Software sees a single address. A read strobe captures the pending status into the read data register. A write strobe loads the enable mask. To acknowledge an event, software writes the mask with that bit cleared, which also disables the source. Writing the bit set again re-arms the source for the next event. Every source input is asynchronous and passes through a synchroniser before any edge is detected.

Each edge source has its own state machine with three states. EG_OFF means the source is disabled and nothing is latched. EG_ARMED means the source is enabled and waiting for an edge. EG_HELD means the source is enabled and an edge is latched. The transitions are:
- enable: EG_OFF to EG_ARMED, on a write with the bit set.
- catch: EG_ARMED to EG_HELD, on a synchronised rising edge.
- disarm: EG_ARMED to EG_OFF, on a write with the bit clear.
- acknowledge: EG_HELD to EG_OFF, on a write with the bit clear.

A write with the bit set leaves EG_ARMED and EG_HELD where they are. The exception is that catch still fires from EG_ARMED during such a write.

Top module: `irq_source_reg`

## Requirements
- R1: After reset, irq is 0, the mask is all zero, and a read returns 8'h00.
- R2: A read strobe (rd_en high at a rising clock edge) loads rdata with the pending status. Bit 0 is the external-edge event, bit 2 is the FIFO level request and bit 5 is the timer-edge event. Bits 1, 3, 4, 6 and 7 always read 0. rdata holds its value while rd_en is low.
- R3: A write strobe (wr_en high at a rising clock edge) loads the mask from wdata[5:0]. wdata[7:6] is ignored. Mask bits 1, 3 and 4 have no source behind them, so setting them never raises irq.
- R4: If an edge source is enabled, a rising edge on its input latches the event. Given an input change just before clock edge k, the status bit is set after edge k+2, and irq rises after that edge when the bit is enabled.
- R5: A rising edge on an edge source whose mask bit is 0 is not latched, and it is not recovered when the source is enabled later.
- R6: A latched edge stays pending after its input falls, and through writes that keep its mask bit at 1.
- R7: A write with an edge source's mask bit at 0 clears that source's latched event, and the source stays clear after it is re-enabled.
- R8: The FIFO level bit (bit 2) follows its input whether or not it is enabled. An input change just before edge k is visible after edge k+1.
- R9: irq is high exactly when some status bit and the same mask bit are both 1. irq is combinational from the status and mask registers.
- R10: After a write of 8'h00, irq is low from the next edge on.
- R11: If a synchronised rising edge arrives in the same cycle as a write that keeps the bit enabled, the edge is latched. If the write clears the bit, the edge is lost.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, loads the mask |
| rd_en | input | 1 | Read strobe, captures status into rdata |
| wdata | input | DATA_W | Write data (mask) |
| rdata | output | DATA_W | Read data (status) |
| ext_trig_in | input | 1 | External trigger, asynchronous, edge source for bit 0 |
| fifo_req_in | input | 1 | FIFO level request, asynchronous, level source for bit 2 |
| timer1_in | input | 1 | Timer output, asynchronous, edge source for bit 5 |
| irq | output | 1 | Interrupt request, active high |

## Verification
Latency is counted from an input change just before clock edge k:
- A level request shows in irq after edge k+1. The bench samples one cycle early to see it still low, then one cycle later to see it high.
- An edge event shows after edge k+2. The bench checks it is still absent after k+1 and present after k+2.
- A mask write affects irq right after the edge that takes it.
- A read shows the status as it stood before the edge that takes the strobe.

Every sample is taken at the falling clock edge. The random phase checks a cycle model in the bench at every falling edge. That model updates on the same rising edges as the design, so the cycle offsets stay aligned. One directed case times a mask write so that it lands on the edge where a synchronised rise is latched.

// File: rtl/irq_source_pkg.sv
package irq_source_pkg;

    localparam int STAT_W = 6;
    localparam int SRC_N  = 3;

    typedef enum logic [1:0] {
        EG_OFF,
        EG_ARMED,
        EG_HELD
    } edge_state_e;

    // Which synchronised source feeds a status bit; -1 means none.
    function automatic int bit_source(input int b);
        case (b)
            0:       return 0;
            2:       return 1;
            5:       return 2;
            default: return -1;
        endcase
    endfunction

    function automatic bit source_is_edge(input int s);
        return (s != 1);
    endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);

    logic [WIDTH-1:0] chain [STAGES];

    generate
        for (genvar g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= '0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    assign sync_out = chain[STAGES-1];

endmodule

// File: rtl/irq_edge_latch.sv
module irq_edge_latch
    import irq_source_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_en,
    input  logic wr_bit,
    input  logic rise,
    output logic pending
);

    edge_state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= EG_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            EG_OFF: begin
                if (wr_en && wr_bit) state_d = EG_ARMED;           // enable
            end
            EG_ARMED: begin
                if (wr_en && !wr_bit) state_d = EG_OFF;            // disarm
                else if (rise)        state_d = EG_HELD;           // catch
            end
            EG_HELD: begin
                if (wr_en && !wr_bit) state_d = EG_OFF;            // acknowledge
            end
            default: state_d = EG_OFF;
        endcase
    end

    always_comb begin
        pending = (state_q == EG_HELD);
    end

endmodule

// File: rtl/irq_source_reg.sv
module irq_source_reg
    import irq_source_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    input  logic              ext_trig_in,
    input  logic              fifo_req_in,
    input  logic              timer1_in,
    output logic              irq
);

    localparam int PAD_W = DATA_W - STAT_W;

    logic [SRC_N-1:0]  src_raw;
    logic [SRC_N-1:0]  src_sync;
    logic [SRC_N-1:0]  src_prev;
    logic [SRC_N-1:0]  src_rise;
    logic [STAT_W-1:0] mask_q;
    logic [STAT_W-1:0] status;

    assign src_raw = {timer1_in, fifo_req_in, ext_trig_in};

    irq_sync #(
        .WIDTH  (SRC_N),
        .STAGES (SYNC_STAGES)
    ) i_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (src_raw),
        .sync_out (src_sync)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) src_prev <= '0;
        else        src_prev <= src_sync;
    end

    assign src_rise = src_sync & ~src_prev;

    always_ff @(posedge clk) begin
        if (!rst_n)     mask_q <= '0;
        else if (wr_en) mask_q <= wdata[STAT_W-1:0];
    end

    generate
        for (genvar b = 0; b < STAT_W; b++) begin : g_bit
            localparam int SRC = bit_source(b);
            if (SRC < 0) begin : g_none
                assign status[b] = 1'b0;
            end else if (source_is_edge(SRC)) begin : g_edge
                irq_edge_latch i_latch (
                    .clk     (clk),
                    .rst_n   (rst_n),
                    .wr_en   (wr_en),
                    .wr_bit  (wdata[b]),
                    .rise    (src_rise[SRC]),
                    .pending (status[b])
                );
            end else begin : g_level
                assign status[b] = src_sync[SRC];
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)     rdata <= '0;
        else if (rd_en) rdata <= {{PAD_W{1'b0}}, status};
    end

    assign irq = |(status & mask_q);

endmodule

// File: rtl/irq_source_reg_chk.sv
module irq_source_reg_chk #(
    parameter int DATA_W = 8,
    parameter int STAT_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic              rd_en,
    input logic [DATA_W-1:0] wdata,
    input logic [DATA_W-1:0] rdata,
    input logic [STAT_W-1:0] mask_q,
    input logic [STAT_W-1:0] status,
    input logic              irq
);

    assert_unused_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> (rdata[1] == 1'b0 && rdata[3] == 1'b0 && rdata[4] == 1'b0
                   && (rdata >> STAT_W) == '0));

    assert_no_mask_no_irq_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_q == '0) |-> !irq);

    assert_write_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[STAT_W-1:0] == '0) |=> !irq);

    assert_disabled_ext_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[0] |=> !status[0]);

    assert_disabled_tmr_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !mask_q[5] |=> !status[5]);

    assert_hold_ext_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[0] && !(wr_en && !wdata[0])) |=> status[0]);

    assert_hold_tmr_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (status[5] && !(wr_en && !wdata[5])) |=> status[5]);

    assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wdata[0]) |=> !status[0]);

endmodule

bind irq_source_reg irq_source_reg_chk #(
    .DATA_W (DATA_W),
    .STAT_W (irq_source_pkg::STAT_W)
) i_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (wr_en),
    .rd_en  (rd_en),
    .wdata  (wdata),
    .rdata  (rdata),
    .mask_q (mask_q),
    .status (status),
    .irq    (irq)
);

// File: tb/test_irq_source_reg.sv
module test_irq_source_reg;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic       ext_trig_in = 1'b0;
    logic       fifo_req_in = 1'b0;
    logic       timer1_in = 1'b0;
    logic       irq;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    irq_source_reg i_irq_source_reg (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .wdata       (wdata),
        .rdata       (rdata),
        .ext_trig_in (ext_trig_in),
        .fifo_req_in (fifo_req_in),
        .timer1_in   (timer1_in),
        .irq         (irq)
    );

    // Cycle model built from the requirements.
    logic [2:0] m_s1, m_s2, m_prev;
    logic [5:0] m_mask;
    logic       m_h0, m_h5;
    logic [7:0] m_rdata;

    function automatic logic [7:0] m_status(input logic h0, input logic lvl, input logic h5);
        return {2'b00, h5, 2'b00, lvl, 1'b0, h0};
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= '0; m_s2 <= '0; m_prev <= '0;
            m_mask <= '0; m_h0 <= 1'b0; m_h5 <= 1'b0; m_rdata <= '0;
        end else begin
            m_s1   <= {timer1_in, fifo_req_in, ext_trig_in};
            m_s2   <= m_s1;
            m_prev <= m_s2;
            if (wr_en) m_mask <= wdata[5:0];
            if (wr_en && !wdata[0])                      m_h0 <= 1'b0;
            else if (m_mask[0] && m_s2[0] && !m_prev[0]) m_h0 <= 1'b1;
            if (wr_en && !wdata[5])                      m_h5 <= 1'b0;
            else if (m_mask[5] && m_s2[2] && !m_prev[2]) m_h5 <= 1'b1;
            if (rd_en) m_rdata <= m_status(m_h0, m_s2[1], m_h5);
        end
    end

    function automatic logic m_irq();
        return |(m_status(m_h0, m_s2[1], m_h5)[5:0] & m_mask);
    endfunction

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic step(input int n);
        repeat (n) begin
            @(posedge clk);
            @(negedge clk);
        end
    endtask

    task automatic write_mask(input logic [7:0] v);
        wr_en = 1'b1; wdata = v;
        step(1);
        wr_en = 1'b0;
    endtask

    task automatic read_reg(output logic [7:0] v);
        rd_en = 1'b1;
        step(1);
        rd_en = 1'b0;
        v = rdata;
    endtask

    initial begin
        #2_000_000;
        if (!done) begin
            n_checks++;
            n_errors++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
            $finish;
        end
    end

    initial begin
        logic [7:0] rv;
        void'($urandom(32'd1234));
        @(negedge clk);
        step(3);
        rst_n = 1'b1;
        step(1);

        // R1 reset state
        check("R1 irq", {7'b0, irq}, 8'h00);
        read_reg(rv);
        check("R1 rdata", rv, 8'h00);

        // R8 level latency and enable independence
        fifo_req_in = 1'b1;
        step(1);
        check("R8 level not yet", {7'b0, irq}, 8'h00);
        step(1);
        read_reg(rv);
        check("R8 level reads while masked", rv, 8'h04);
        check("R9 masked level no irq", {7'b0, irq}, 8'h00);

        // R3 unused mask bits and ignored upper bits
        write_mask(8'hDA);
        check("R3 unused bits no irq", {7'b0, irq}, 8'h00);
        write_mask(8'h04);
        check("R9 level enabled irq", {7'b0, irq}, 8'h01);
        fifo_req_in = 1'b0;
        step(2);
        check("R8 level follows fall", {7'b0, irq}, 8'h00);

        // R4 edge latency
        write_mask(8'h01);
        ext_trig_in = 1'b1;
        step(2);
        check("R4 edge not yet", {7'b0, irq}, 8'h00);
        step(1);
        check("R4 edge latched", {7'b0, irq}, 8'h01);
        ext_trig_in = 1'b0;
        step(3);
        read_reg(rv);
        check("R6 held after input fall", rv, 8'h01);
        write_mask(8'h21);
        check("R6 held through keep write", {7'b0, irq}, 8'h01);

        // R7/R10 acknowledge
        write_mask(8'h00);
        check("R10 zero write drops irq", {7'b0, irq}, 8'h00);
        write_mask(8'h01);
        check("R7 cleared after re-enable", {7'b0, irq}, 8'h00);
        read_reg(rv);
        check("R7 status cleared", rv, 8'h00);

        // R5 edge while disabled
        write_mask(8'h00);
        timer1_in = 1'b1;
        step(4);
        timer1_in = 1'b0;
        step(3);
        write_mask(8'h20);
        check("R5 disabled edge not latched", {7'b0, irq}, 8'h00);
        read_reg(rv);
        check("R5 status bit5 clear", rv, 8'h00);

        // R11 edge coinciding with a keep write
        timer1_in = 1'b1;
        step(2);
        write_mask(8'h20);
        check("R11 edge with keep write latched", {7'b0, irq}, 8'h01);
        read_reg(rv);
        check("R2 timer edge at bit5", rv, 8'h20);
        timer1_in = 1'b0;
        write_mask(8'h00);
        write_mask(8'h20);
        step(3);
        // R11 edge coinciding with a clear write is lost
        timer1_in = 1'b1;
        step(2);
        write_mask(8'h00);
        write_mask(8'h20);
        check("R11 edge with clear write lost", {7'b0, irq}, 8'h00);
        timer1_in = 1'b0;
        step(3);

        // Random phase against the cycle model (R2, R9 and all others)
        for (int i = 0; i < 3000; i++) begin
            logic did_rd;
            ext_trig_in = ($urandom_range(3) == 0);
            fifo_req_in = ($urandom_range(3) == 0);
            timer1_in   = ($urandom_range(3) == 0);
            wr_en       = ($urandom_range(7) == 0);
            wdata       = 8'($urandom);
            rd_en       = ($urandom_range(3) == 0);
            did_rd      = rd_en;
            step(1);
            check("R9 random irq", {7'b0, irq}, {7'b0, m_irq()});
            if (did_rd) check("R2 random rdata", rdata, m_rdata);
        end
        wr_en = 1'b0;
        rd_en = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule